// File: doc/BRIEF.md
# Core-Local Interrupt Controller

This block gathers the interrupt lines that belong to one small processor core and turns them into a single request. Each source has four control fields: a pending flag, an enable flag, an attribute byte and a control byte. The attribute byte chooses level, rising-edge or falling-edge capture, and it can also mark the source for hardware vectoring. Every raw line passes through a two-stage synchronizer before any edge or level test is applied to it.

The control byte is left-aligned. A runtime level-bit count in the configuration register divides it into a level part at the top and a priority part below that. Control bits below the implemented width always read back as ones. The arbiter chooses among sources that are both pending and enabled. It compares level first, then the remaining control bits, and then picks the larger source number. The core sees a request only when the winning level is strictly above a threshold register. The core answers with a one-cycle claim pulse, which clears the pending flag of the edge-captured source currently presented.

Software reaches the block through a word-addressed register bus with byte strobes. Writes take effect at the next clock edge. Read data is combinational while the bus is selected.

Top module: `irq_hub`

## Requirements
- R1: After reset, the configuration, threshold and all per-source fields read zero, except that the low (8 − CTL_BITS) bits of each control byte read as ones (0x0F in byte 3 with CTL_BITS = 4).
- R2: Word 1 is read-only. It returns the source count in bits 12:0, VERSION in bits 20:13 and CTL_BITS in bits 24:21. Writes to it have no effect.
- R3: A source word at word address SRC_WBASE + i places pending in bit 0, enable in bit 8, attribute bits 2:0 in bits 18:16 and the control byte in bits 31:24. All other bits read zero. The configuration word (address 0) keeps only bits 4:1, which hold the level-bit count. The threshold (address 2) keeps bits 7:0.
- R4: Only the top CTL_BITS bits of a control byte are stored. Every lower bit reads as one.
- R5: With trigger 0 (level), or with the unused code 3, the pending bit follows the synchronized input. Software writes to it are ignored.
- R6: With trigger 1 (rising edge), a 0-to-1 change on the synchronized input sets pending. Pending then holds after the input falls, until a claim clears it.
- R7: With trigger 2 (falling edge), a 1-to-0 change sets pending. A rising change does not set it. A claim clears it.
- R8: For an edge-triggered source, a write to bit 0 of the pending byte sets or clears the pending bit.
- R9: Only sources that are pending and enabled compete. The higher level wins. On equal levels, the higher control byte wins. On a full tie, the higher source number wins.
- R10: A source's level is its control byte with every bit below the top n bits forced to one, where n is the level-bit count limited to 8. When n = 0, the level is 0xFF.
- R11: irq_req is high only when the winning level is strictly greater than the threshold.
- R12: irq_shv equals attribute bit 0 of the presented source.
- R13: A read of any unmapped word address returns zero. A write is visible on a read in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | NUM_SRC | Raw interrupt lines |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | AW | Word address |
| bus_be | input | 4 | Byte strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high |
| irq_req | output | 1 | Request to the core |
| irq_id | output | ID_W | Number of the presented source |
| irq_level | output | 8 | Level of the presented source |
| irq_shv | output | 1 | Presented source uses hardware vectoring |
| irq_claim | input | 1 | One-cycle claim of the presented source |

## Verification
The assertions assume that irq_claim is a single-cycle pulse raised only while irq_req is high. They also assume that raw lines hold each value for at least two clocks, so that the synchronizer cannot drop an edge. The stimulus changes lines and bus inputs only on falling clock edges and holds every raw line for two or more cycles. It claims only after it has seen a request, and it releases the claim after a single cycle.

// File: rtl/irq_hub_pkg.sv
// Shared types and helpers for the interrupt hub.
// Assumes a control byte that is 8 bits wide and left-aligned.
package irq_hub_pkg;

    // Trigger selection held in attribute bits 2:1
    typedef enum logic [1:0] {
        TRG_LEVEL = 2'd0,
        TRG_RISE  = 2'd1,
        TRG_FALL  = 2'd2,
        TRG_RSVD  = 2'd3
    } trig_e;

    // Level of a source: bits below the top nlb bits are forced to one
    function automatic logic [7:0] level_of(input logic [7:0] ctl, input logic [3:0] nlb);
        logic [3:0] n;
        n = (nlb > 4'd8) ? 4'd8 : nlb;
        return ctl | (8'hFF >> n);
    endfunction

endpackage

// File: rtl/irq_hub_sync.sv
// Multi-stage synchronizer for raw interrupt lines.
// Assumes each line holds a value for at least STAGES clocks.
module irq_hub_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    // Shift the raw lines through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/irq_hub_src.sv
// One interrupt source: pending capture, enable, attribute and control byte.
// Assumes sync_in is already synchronized. claim_i is high only when this
// source is the one currently presented and the core claims it.
module irq_hub_src
    import irq_hub_pkg::*;
#(
    parameter int CTL_BITS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_in,
    input  logic       claim_i,
    input  logic       wr_pend,
    input  logic       wr_en,
    input  logic       wr_attr,
    input  logic       wr_ctl,
    input  logic [7:0] wb_pend,
    input  logic [7:0] wb_en,
    input  logic [7:0] wb_attr,
    input  logic [7:0] wb_ctl,
    output logic       pend_o,
    output logic       en_o,
    output logic       shv_o,
    output logic [7:0] attr_rd_o,
    output logic [7:0] ctl_rd_o
);
    localparam int         SHIFT    = 8 - CTL_BITS;
    localparam logic [7:0] LOW_ONES = 8'((1 << SHIFT) - 1);

    logic                prev_q;
    logic                pend_q;
    logic                pend_nxt;
    logic                en_q;
    logic                shv_q;
    trig_e               trig_q;
    logic [CTL_BITS-1:0] ctl_q;
    logic                is_edge;
    logic                edge_hit;
    logic                unused_wbits;

    assign is_edge  = (trig_q == TRG_RISE) || (trig_q == TRG_FALL);
    assign edge_hit = ((trig_q == TRG_RISE) &&  sync_in && !prev_q) ||
                      ((trig_q == TRG_FALL) && !sync_in &&  prev_q);

    // Next pending state: edge capture beats software, which beats claim
    always_comb begin
        pend_nxt = pend_q;
        if (!is_edge)      pend_nxt = 1'b0;
        else if (edge_hit) pend_nxt = 1'b1;
        else if (wr_pend)  pend_nxt = wb_pend[0];
        else if (claim_i)  pend_nxt = 1'b0;
    end

    // Register the source state and the previous synchronized value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
            en_q   <= 1'b0;
            shv_q  <= 1'b0;
            trig_q <= TRG_LEVEL;
            ctl_q  <= '0;
        end else begin
            prev_q <= sync_in;
            pend_q <= pend_nxt;
            if (wr_en) en_q <= wb_en[0];
            if (wr_attr) begin
                shv_q  <= wb_attr[0];
                trig_q <= trig_e'(wb_attr[2:1]);
            end
            if (wr_ctl) ctl_q <= wb_ctl[7 -: CTL_BITS];
        end
    end

    assign pend_o       = is_edge ? pend_q : sync_in;
    assign en_o         = en_q;
    assign shv_o        = shv_q;
    assign attr_rd_o    = {5'b0, trig_q, shv_q};
    assign ctl_rd_o     = (8'(ctl_q) << SHIFT) | LOW_ONES;
    assign unused_wbits = ^{wb_pend[7:1], wb_en[7:1], wb_attr[7:3], wb_ctl};

    // R6 R7
    pend_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> ($past(edge_hit) || $past(wr_pend && wb_pend[0])));

    // R6
    claim_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_i && is_edge && !edge_hit && !wr_pend) |=> !pend_q);

endmodule

// File: rtl/irq_hub_arb.sv
// Selects the winner among pending, enabled sources and gates it with the
// threshold. Assumes the level and control inputs come from registered state.
module irq_hub_arb #(
    parameter int NUM_SRC = 8,
    parameter int ID_W    = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      valid_i,
    input  logic [NUM_SRC-1:0][7:0] lvl_i,
    input  logic [NUM_SRC-1:0][7:0] ctl_i,
    input  logic [NUM_SRC-1:0]      shv_i,
    input  logic [7:0]              thr_i,
    output logic                    req_o,
    output logic [ID_W-1:0]         id_o,
    output logic [7:0]              lvl_o,
    output logic                    shv_o
);
    logic        win_v;
    logic [15:0] win_key;

    // Linear scan; >= lets the higher index win a full tie
    always_comb begin
        win_v   = 1'b0;
        win_key = '0;
        id_o    = '0;
        shv_o   = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (valid_i[i] && (!win_v || ({lvl_i[i], ctl_i[i]} >= win_key))) begin
                win_v   = 1'b1;
                win_key = {lvl_i[i], ctl_i[i]};
                id_o    = ID_W'(i);
                shv_o   = shv_i[i];
            end
        end
    end

    assign lvl_o = win_key[15:8];
    assign req_o = win_v && (win_key[15:8] > thr_i);

    // R9
    win_is_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> valid_i[id_o]);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_win
        // R9
        no_better_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_o && valid_i[g]) |-> ({lvl_i[g], ctl_i[g]} <= win_key));
    end

endmodule

// File: rtl/irq_hub.sv
// Core-local interrupt hub: register bus decode, per-source cells,
// level computation and arbitration. Assumes single-cycle bus accesses
// with word addresses, and one-cycle claim pulses from the core.
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int          NUM_SRC   = 8,
    parameter int          CTL_BITS  = 4,
    parameter int          VERSION   = 1,
    parameter int          AW        = 10,
    parameter int          SRC_WBASE = 256,
    parameter int          ID_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_waddr,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_req,
    output logic [ID_W-1:0]    irq_id,
    output logic [7:0]         irq_level,
    output logic               irq_shv,
    input  logic               irq_claim
);
    localparam logic [AW-1:0] CFG_W   = AW'(0);
    localparam logic [AW-1:0] INFO_W  = AW'(1);
    localparam logic [AW-1:0] THR_W   = AW'(2);
    localparam logic [AW-1:0] BASE_W  = AW'(SRC_WBASE);
    localparam logic [AW-1:0] CNT_W   = AW'(NUM_SRC);
    localparam logic [31:0]   INFO    = {7'b0, 4'(CTL_BITS), 8'(VERSION), 13'(NUM_SRC)};

    logic [3:0]              nlb_q;
    logic [7:0]              thr_q;
    logic [NUM_SRC-1:0]      sync_vec;
    logic [NUM_SRC-1:0]      pend_vec;
    logic [NUM_SRC-1:0]      en_vec;
    logic [NUM_SRC-1:0]      shv_vec;
    logic [NUM_SRC-1:0][7:0] attr_vec;
    logic [NUM_SRC-1:0][7:0] ctl_vec;
    logic [NUM_SRC-1:0][7:0] lvl_vec;
    logic [AW-1:0]           src_off;
    logic                    src_hit;
    logic [ID_W-1:0]         src_idx;
    logic                    wr_cycle;

    assign wr_cycle = bus_sel && bus_wr;
    assign src_off  = bus_waddr - BASE_W;
    assign src_hit  = (bus_waddr >= BASE_W) && (src_off < CNT_W);
    assign src_idx  = src_off[ID_W-1:0];

    // Global configuration and threshold registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nlb_q <= '0;
            thr_q <= '0;
        end else if (wr_cycle && bus_be[0]) begin
            if (bus_waddr == CFG_W) nlb_q <= bus_wdata[4:1];
            if (bus_waddr == THR_W) thr_q <= bus_wdata[7:0];
        end
    end

    irq_hub_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (2)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (irq_src),
        .q_o   (sync_vec)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic hit_g;
        logic claim_g;

        assign hit_g   = wr_cycle && src_hit && (src_idx == ID_W'(g));
        assign claim_g = irq_claim && irq_req && (irq_id == ID_W'(g));

        irq_hub_src #(
            .CTL_BITS (CTL_BITS)
        ) i_src (
            .clk       (clk),
            .rst_n     (rst_n),
            .sync_in   (sync_vec[g]),
            .claim_i   (claim_g),
            .wr_pend   (hit_g && bus_be[0]),
            .wr_en     (hit_g && bus_be[1]),
            .wr_attr   (hit_g && bus_be[2]),
            .wr_ctl    (hit_g && bus_be[3]),
            .wb_pend   (bus_wdata[7:0]),
            .wb_en     (bus_wdata[15:8]),
            .wb_attr   (bus_wdata[23:16]),
            .wb_ctl    (bus_wdata[31:24]),
            .pend_o    (pend_vec[g]),
            .en_o      (en_vec[g]),
            .shv_o     (shv_vec[g]),
            .attr_rd_o (attr_vec[g]),
            .ctl_rd_o  (ctl_vec[g])
        );

        assign lvl_vec[g] = level_of(ctl_vec[g], nlb_q);
    end

    irq_hub_arb #(
        .NUM_SRC (NUM_SRC),
        .ID_W    (ID_W)
    ) i_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (pend_vec & en_vec),
        .lvl_i   (lvl_vec),
        .ctl_i   (ctl_vec),
        .shv_i   (shv_vec),
        .thr_i   (thr_q),
        .req_o   (irq_req),
        .id_o    (irq_id),
        .lvl_o   (irq_level),
        .shv_o   (irq_shv)
    );

    // Read data multiplexer; unmapped words return zero
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            if (src_hit) begin
                bus_rdata = {ctl_vec[src_idx], attr_vec[src_idx],
                             7'b0, en_vec[src_idx], 7'b0, pend_vec[src_idx]};
            end else if (bus_waddr == CFG_W) begin
                bus_rdata = {27'b0, nlb_q, 1'b0};
            end else if (bus_waddr == INFO_W) begin
                bus_rdata = INFO;
            end else if (bus_waddr == THR_W) begin
                bus_rdata = {24'b0, thr_q};
            end
        end
    end

    // R11
    req_above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level > thr_q));

    // R12
    shv_matches_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_shv == shv_vec[irq_id]));

endmodule

// File: tb/test_irq_hub.sv
module test_irq_hub;
    localparam int NUM_SRC = 8;
    localparam int AW      = 10;
    localparam int NVEC    = 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] irq_src = '0;
    logic               bus_sel = 1'b0;
    logic               bus_wr = 1'b0;
    logic [AW-1:0]      bus_waddr = '0;
    logic [3:0]         bus_be = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic               irq_req;
    logic [2:0]         irq_id;
    logic [7:0]         irq_level;
    logic               irq_shv;
    logic               irq_claim = 1'b0;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    irq_hub i_irq_hub (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src   (irq_src),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_waddr (bus_waddr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .irq_id    (irq_id),
        .irq_level (irq_level),
        .irq_shv   (irq_shv),
        .irq_claim (irq_claim)
    );

    // {word address, write data, expected read-back}
    localparam logic [73:0] VEC [NVEC] = '{
        {10'h000, 32'h0000_00FF, 32'h0000_001E},  // R3 config keeps bits 4:1
        {10'h002, 32'hFFFF_FFAB, 32'h0000_00AB},  // R3 threshold byte
        {10'h001, 32'hFFFF_FFFF, 32'h0080_2008},  // R2 info is read-only
        {10'h100, 32'hFFFF_FFFF, 32'hFF07_0100},  // R3 R4 R5 pend write ignored (level)
        {10'h100, 32'h0000_0000, 32'h0F00_0000},  // R4 low control bits read one
        {10'h107, 32'hA504_0101, 32'hAF04_0100},  // R4 R5 trig was level at write
        {10'h107, 32'hA504_0101, 32'hAF04_0101},  // R8 edge source pend settable
        {10'h107, 32'h0000_0000, 32'h0F00_0000},  // R8 edge source pend clearable
        {10'h108, 32'hFFFF_FFFF, 32'h0000_0000},  // R13 past last source
        {10'h003, 32'hFFFF_FFFF, 32'h0000_0000},  // R13 unmapped word
        {10'h002, 32'h0000_0000, 32'h0000_0000},  // R13 threshold cleared
        {10'h000, 32'h0000_0000, 32'h0000_0000}   // R13 config cleared
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic claim();
        @(negedge clk);
        irq_claim = 1'b1;
        @(negedge clk);
        irq_claim = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic req_state(output logic [31:0] s);
        #1 s = {20'b0, irq_shv, irq_level, irq_req, 2'b0, irq_id} & 32'h0000_1FF7;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R13 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(10'h103, rd); chk("R1 src3 word", rd, 32'h0F00_0000);
        bus_read(10'h000, rd); chk("R1 config", rd, 32'h0);
        bus_read(10'h002, rd); chk("R1 threshold", rd, 32'h0);
        chk("R1 no request", {31'b0, irq_req}, 32'h0);

        // Register table walk
        for (int k = 0; k < NVEC; k++) begin
            bus_write(VEC[k][73:64], VEC[k][63:32], 4'hF);
            bus_read(VEC[k][73:64], rd);
            chk($sformatf("R2/R3/R4/R8/R13 row %0d", k), rd, VEC[k][31:0]);
        end

        // R5 level source 1, nlbits 0 gives level FF (R10)
        bus_write(10'h101, 32'h0000_0100, 4'hF);
        @(negedge clk); irq_src[1] = 1'b1;
        wait_cyc(3);
        chk("R5 level req", {31'b0, irq_req}, 32'h1);
        chk("R5 level id", 32'(irq_id), 32'h1);
        chk("R10 nlbits 0 level", 32'(irq_level), 32'hFF);
        bus_write(10'h101, 32'h0, 4'h1);
        bus_read(10'h101, rd); chk("R5 pend write ignored", rd & 32'h1, 32'h1);
        irq_src[1] = 1'b0;
        wait_cyc(3);
        chk("R5 level follows input", {31'b0, irq_req}, 32'h0);

        // R6 rising edge on source 2
        bus_write(10'h102, 32'h0002_0100, 4'hF);
        irq_src[2] = 1'b1; wait_cyc(2); irq_src[2] = 1'b0;
        wait_cyc(4);
        chk("R6 rise held", {31'b0, irq_req}, 32'h1);
        chk("R6 rise id", 32'(irq_id), 32'h2);
        claim();
        chk("R6 claim clears", {31'b0, irq_req}, 32'h0);

        // R7 falling edge on source 3
        bus_write(10'h103, 32'h0004_0100, 4'hF);
        irq_src[3] = 1'b1; wait_cyc(4);
        chk("R7 rise ignored", {31'b0, irq_req}, 32'h0);
        irq_src[3] = 1'b0; wait_cyc(4);
        chk("R7 fall id", {31'b0, irq_req, 1'b0, irq_id}, 32'h13);
        claim();
        chk("R7 claim clears", {31'b0, irq_req}, 32'h0);

        // R8 software pending on source 4
        bus_write(10'h104, 32'h0002_0100, 4'hF);
        bus_write(10'h104, 32'h0002_0101, 4'hF);
        chk("R8 sw set", {31'b0, irq_req, 1'b0, irq_id}, 32'h14);
        bus_write(10'h104, 32'h0002_0100, 4'hF);
        chk("R8 sw clear", {31'b0, irq_req}, 32'h0);

        // R9 R10 arbitration with nlbits = 2
        bus_write(10'h000, 32'h0000_0004, 4'hF);
        bus_write(10'h105, 32'h8002_0100, 4'hF);
        bus_write(10'h105, 32'h8002_0101, 4'hF);
        bus_write(10'h106, 32'h4002_0100, 4'hF);
        bus_write(10'h106, 32'h4002_0101, 4'hF);
        chk("R9 higher level wins", 32'(irq_id), 32'h5);
        chk("R10 level nlbits 2", 32'(irq_level), 32'hBF);
        bus_write(10'h106, 32'h8002_0101, 4'hF);
        chk("R9 tie higher id", 32'(irq_id), 32'h6);
        bus_write(10'h105, 32'h9002_0101, 4'hF);
        chk("R9 priority bits", 32'(irq_id), 32'h5);

        // R11 threshold is strict
        bus_write(10'h002, 32'h0000_00BF, 4'hF);
        chk("R11 equal blocks", {31'b0, irq_req}, 32'h0);
        bus_write(10'h002, 32'h0000_00BE, 4'hF);
        chk("R11 below passes", {31'b0, irq_req}, 32'h1);

        // R9 disabled source drops out; R12 vectoring flag
        bus_write(10'h105, 32'h9002_0001, 4'hF);
        chk("R9 disabled skipped", 32'(irq_id), 32'h6);
        bus_write(10'h106, 32'h8003_0101, 4'hF);
        chk("R12 shv", {31'b0, irq_shv}, 32'h1);

        // R10 nlbits 9 limited to 8
        bus_write(10'h000, 32'h0000_0012, 4'hF);
        chk("R10 clamp blocks", {31'b0, irq_req}, 32'h0);
        bus_write(10'h002, 32'h0000_008E, 4'hF);
        req_state(rd);
        chk("R10 clamp level", 32'(irq_level), 32'h8F);
        chk("R10 clamp req", {31'b0, irq_req}, 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule